// File: doc/BRIEF.md
# Core Event Controller Register Front End

This block is the software-facing register set of a core interrupt event controller. A memory-mapped bus that accepts only full 32-bit accesses reaches five registers: a free-form override word, an interrupt enable mask, a read-only pending word, a latch that records arriving events, and a priority word that keeps only a few of its bits. Hardware events come in on a 16-bit input and set latch bits. Software acknowledges events by writing ones to the latch.

The block keeps a registered interrupt request. The request is high whenever any latched event is also enabled in the mask. The pending word is supplied by the vectoring sequencer next to this block, and this block only presents it for reading. Reads are combinational in the cycle of the access. Writes take effect at the clock edge that ends the access.

Top module: `evc_top`

## Requirements
- R1: An access with a size code other than word (`busSize` encoding: 0 = byte, 1 = half, 2 = word, 3 = reserved) raises `busErr` in the same cycle, changes no register, and returns read data 0.
- R2: A word access to any offset leaves `busErr` low.
- R3: The override register at offset 0x00 stores and returns all 32 written bits.
- R4: The mask register at offset 0x04 stores the written value, and bits 0 to 4 always read back as 1.
- R5: A read at offset 0x08 returns `activeIn`. Writes to that offset change nothing.
- R6: A write to the latch at offset 0x0C clears each latch bit written as 1 that lies inside 0xFFEE. Latch bits 0 and 4 are never cleared by software.
- R7: A 1 on `eventIn[i]` sets latch bit i at the next edge. It wins over a software clear of the same bit in the same cycle.
- R8: A write to the priority register at offset 0x10 keeps only bits 0 to 4. Every other bit reads back as 0.
- R9: `irqOut` equals the OR of (latch AND effective mask) as it stood one clock earlier. It therefore follows a mask or latch change one cycle after that change.
- R10: After reset the override, latch and priority registers read 0, the mask reads 0x0000001F, and `irqOut` is low.
- R11: Word reads of unmapped offsets return 0. Word writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | Access size code |
| busAddr | input | 8 | Byte offset within the block |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| busErr | output | 1 | Access size rejected |
| eventIn | input | 16 | Event strobes, one per latch bit |
| activeIn | input | 32 | Pending word from the sequencer |
| irqOut | output | 1 | Registered interrupt request |

## Verification
A corrupted latch or mask shows up in two ways. A direct read returns the wrong value in the same cycle. `irqOut` rises or fails to rise exactly one edge after the faulty bit is stored. The bench checks `irqOut` both before and after that edge, so an off-by-one in the request register is caught. A size check that slips through shows up as a register whose value moved when the bench reads it back.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int DATA_W = 32;
  localparam logic [31:0] CLR_MASK = 32'h0000_FFEE;
  localparam logic [31:0] UNMASK_BITS = 32'h0000_001F;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  localparam logic [7:0] OFF_OVR   = 8'h00;
  localparam logic [7:0] OFF_MASK  = 8'h04;
  localparam logic [7:0] OFF_PEND  = 8'h08;
  localparam logic [7:0] OFF_LATCH = 8'h0C;
  localparam logic [7:0] OFF_PRI   = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_OVR, SEL_MASK, SEL_PEND, SEL_LATCH, SEL_PRI
  } regSel_e;

  typedef struct packed {
    logic    wrOvr;
    logic    wrMask;
    logic    wrLatch;
    logic    wrPri;
    regSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/evc_ctrl.sv
module evc_ctrl
  import evc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busErr,
  output strobe_t           strb
);
  logic sizeOk;
  logic wrGo;
  logic rdGo;
  regSel_e target;

  assign sizeOk = (busSize == SIZE_WORD);
  assign busErr = busSel && !sizeOk;
  assign wrGo   = busSel && sizeOk && busWrite;
  assign rdGo   = busSel && sizeOk && !busWrite;

  always_comb begin
    target = SEL_NONE;
    case (8'(busAddr))
      OFF_OVR:   target = SEL_OVR;
      OFF_MASK:  target = SEL_MASK;
      OFF_PEND:  target = SEL_PEND;
      OFF_LATCH: target = SEL_LATCH;
      OFF_PRI:   target = SEL_PRI;
      default:   target = SEL_NONE;
    endcase
  end

  always_comb begin
    strb.wrOvr   = wrGo && (target == SEL_OVR);
    strb.wrMask  = wrGo && (target == SEL_MASK);
    strb.wrLatch = wrGo && (target == SEL_LATCH);
    strb.wrPri   = wrGo && (target == SEL_PRI);
    strb.rdSel   = rdGo ? target : SEL_NONE;
  end

  // R1
  size_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> ($countones({strb.wrOvr, strb.wrMask, strb.wrLatch, strb.wrPri}) == 0
                && strb.rdSel == SEL_NONE));

  // R5
  pend_ro_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && 8'(busAddr) == OFF_PEND) |->
      !(strb.wrOvr || strb.wrMask || strb.wrLatch || strb.wrPri));

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrOvr, strb.wrMask, strb.wrLatch, strb.wrPri}));
endmodule

// File: rtl/evc_dp.sv
module evc_dp
  import evc_pkg::*;
#(
  parameter int EVT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [EVT_W-1:0]  eventIn,
  input  logic [DATA_W-1:0] activeIn,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  localparam logic [EVT_W-1:0] CLR_EVT = EVT_W'(CLR_MASK);

  logic [DATA_W-1:0] ovrQ, maskQ, priQ, maskEff;
  logic [EVT_W-1:0]  latchQ, clrBits;
  logic              irqQ;

  assign maskEff = maskQ | UNMASK_BITS;
  assign clrBits = strb.wrLatch ? (busWdata[EVT_W-1:0] & CLR_EVT) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovrQ   <= '0;
      maskQ  <= '0;
      priQ   <= '0;
      latchQ <= '0;
      irqQ   <= 1'b0;
    end else begin
      if (strb.wrOvr)  ovrQ  <= busWdata;
      if (strb.wrMask) maskQ <= busWdata;
      if (strb.wrPri)  priQ  <= busWdata & UNMASK_BITS;
      latchQ <= (latchQ & ~clrBits) | eventIn;
      irqQ   <= |(DATA_W'(latchQ) & maskEff);
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_OVR:   busRdata = ovrQ;
      SEL_MASK:  busRdata = maskEff;
      SEL_PEND:  busRdata = activeIn;
      SEL_LATCH: busRdata = DATA_W'(latchQ);
      SEL_PRI:   busRdata = priQ;
      default:   busRdata = '0;
    endcase
  end

  assign irqOut = irqQ;

  // R6
  sticky_bit0_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchQ[0] |=> latchQ[0]);
  // R6
  sticky_bit4_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchQ[4] |=> latchQ[4]);
  // R7
  event_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|eventIn) |=> ((latchQ & $past(eventIn)) == $past(eventIn)));
  // R9
  unmaskable_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchQ[0] |=> irqOut);
  // R4
  mask_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == SEL_MASK) |-> (busRdata[4:0] == 5'h1F));
  // R8
  pri_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == SEL_PRI) |-> (busRdata[31:5] == '0));
endmodule

// File: rtl/evc_top.sv
module evc_top
  import evc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int EVT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busErr,
  input  logic [EVT_W-1:0]  eventIn,
  input  logic [31:0]       activeIn,
  output logic              irqOut
);
  strobe_t strb;

  evc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busSize(busSize), .busAddr(busAddr), .busErr(busErr), .strb(strb)
  );

  evc_dp #(.EVT_W(EVT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .eventIn(eventIn), .activeIn(activeIn), .busRdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_evc_top.sv
`timescale 1ns/1ps
module sim_evc_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [1:0] busSize = 2'd2;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0, activeIn = '0, busRdata;
  logic [15:0] eventIn = '0;
  logic busErr, irqOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evc_top u0 (.clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busSize(busSize), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .eventIn(eventIn), .activeIn(activeIn), .irqOut(irqOut));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d; busSize = sz;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0; busSize = 2'd2;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, output logic e, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a; busSize = sz;
    #1; d = busRdata; e = busErr;
    @(posedge clk); #1;
    busSel = 0; busSize = 2'd2;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    rd(8'h00, d, e); check("R10 ovr", d, 0); check("R2 err", {31'b0, e}, 0);
    rd(8'h04, d, e); check("R10 mask", d, 32'h1F);
    rd(8'h0C, d, e); check("R10 latch", d, 0);
    rd(8'h10, d, e); check("R10 pri", d, 0);
    check("R10 irq", {31'b0, irqOut}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d; logic e;
    wr(8'h00, 32'hDEAD_BEEF); rd(8'h00, d, e); check("R3 ovr", d, 32'hDEAD_BEEF);
    wr(8'h04, 32'h0000_0000); rd(8'h04, d, e); check("R4 mask forced", d, 32'h1F);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d, e); check("R8 pri", d, 32'h1F);
    activeIn = 32'h1234_5678;
    wr(8'h08, 32'hFFFF_0000); rd(8'h08, d, e); check("R5 pend", d, 32'h1234_5678);
    rd(8'h00, d, e); check("R5 no side effect", d, 32'hDEAD_BEEF);
    wr(8'h14, 32'h5555_5555); rd(8'h14, d, e); check("R11 unmapped rd", d, 0);
    rd(8'h00, d, e); check("R11 ovr kept", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_size();
    logic [31:0] d; logic e;
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 8'h00; busWdata = 32'h0000_AAAA; busSize = 2'd1;
    #1; check("R1 err on half wr", {31'b0, busErr}, 1);
    @(posedge clk); #1; busSel = 0; busWrite = 0; busSize = 2'd2;
    rd(8'h00, d, e); check("R1 ovr unchanged", d, 32'hDEAD_BEEF);
    rd(8'h00, d, e, 2'd0); check("R1 byte rd err", {31'b0, e}, 1); check("R1 rd data", d, 0);
    wr(8'h04, 32'hFFFF_FFE0, 2'd3); rd(8'h04, d, e); check("R1 mask unchanged", d, 32'h1F);
  endtask

  task automatic t_irq();
    logic [31:0] d; logic e;
    @(negedge clk); eventIn = 16'h0020;
    @(negedge clk); eventIn = 0;
    rd(8'h0C, d, e); check("R7 latch set", d, 32'h20);
    check("R9 masked no irq", {31'b0, irqOut}, 0);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 8'h04; busWdata = 32'h20;
    @(posedge clk); #1; busSel = 0; busWrite = 0;
    check("R9 irq not before next edge", {31'b0, irqOut}, 0);
    @(posedge clk); #1;
    check("R9 irq one edge later", {31'b0, irqOut}, 1);
    wr(8'h0C, 32'h20);
    check("R9 irq lag after clear", {31'b0, irqOut}, 1);
    @(posedge clk); #1;
    check("R9 irq drops", {31'b0, irqOut}, 0);
    rd(8'h0C, d, e); check("R6 clear bit5", d, 0);
  endtask

  task automatic t_race();
    logic [31:0] d; logic e;
    @(negedge clk); eventIn = 16'h0080;
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 8'h0C; busWdata = 32'h80;
    @(posedge clk); #1; busSel = 0; busWrite = 0; eventIn = 0;
    rd(8'h0C, d, e); check("R7 event beats clear", d, 32'h80);
    wr(8'h0C, 32'h80); rd(8'h0C, d, e); check("R6 clear alone", d, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d; logic e;
    @(negedge clk); eventIn = 16'h8013;
    @(negedge clk); eventIn = 0;
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d, e); check("R6 bits 0 and 4 kept", d, 32'h11);
    @(posedge clk); #1;
    check("R9 unmaskable irq", {31'b0, irqOut}, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset(); t_regs(); t_size(); t_irq(); t_race(); t_sticky();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule